// File: doc/BRIEF.md
# Programmable Even-Ratio Clock Divider with Output Retiming

This block divides a fast clock by a programmable even ratio between 16 and 30. A fixed divide-by-two stage feeds a cascade of three divide-by-two-or-three cells. Each cell has one bit of a 3-bit ratio word. A cell whose bit is set stretches exactly one of its output cycles to three input cycles in each output period. In every other cycle of that period it divides by two. The ratio is N = 2 x (8 + 4*w[2] + 2*w[1] + w[0]), where w is the ratio word.

The ratio word is captured once per period, at the boundary where every cell wraps together. A change made in the middle of a period therefore cannot split a period between two ratios. This is the property a fractional sequence generator upstream relies on when it updates the word every period. The output is not taken from the cascade directly. A retiming flop in the fast clock domain sets when all cells sit on their terminal count and clears in the state just before that. Every rising edge of the output therefore lands on a fast clock edge, and only that rising edge matters to the phase detector downstream.

Top module: `mmd_divider`

## Requirements
- R1: While rst_ni is low, div_o is 0.
- R2: With the ratio word w held, successive rising edges of div_o are exactly 2 x (8 + 4*w[2] + 2*w[1] + w[0]) fast clock cycles apart. This gives 16 for w = 0 and 30 for w = 7.
- R3: div_o rises exactly once per output period and never between the scheduled rising edges.
- R4: ratio_sel_i is sampled only at the fast clock edge one cycle after each rising edge of div_o, which is the period boundary. The value present there sets the length of the period that ends at the next rising edge. A change at any other time has no effect until the following boundary.
- R5: In each period div_o is low for exactly 2 x (1 + w[0]) cycles just before its rising edge, where w is the word governing that period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ratio_sel_i | input | 3 | Ratio word w; bit k drives cell k, and bit 0 belongs to the cell nearest the prescaler |
| div_o | output | 1 | Retimed divided clock; its rising edge is significant |

## Verification
A wrong count in any cell shifts the next rising edge of div_o by a multiple of two cycles, and the shift is visible within one output period. A ratio latch that loads at the wrong moment shows up as a period whose length follows a word changed mid-period. It is caught at the first rising edge after that change. A faulty set or clear decode changes the low width, or adds or removes a rising edge, in the same period. Comparing the expected rising edge with div_o on every cycle therefore localises each fault to within one period.

// File: rtl/mmd_pkg.sv
package mmd_pkg;
  typedef logic [1:0] cell_cnt_t;

  function automatic int unsigned ratio_of(input int unsigned n_cells, input int unsigned word);
    return 2 * ((1 << n_cells) + word);
  endfunction
endpackage

// File: rtl/mmd_prescaler.sv
module mmd_prescaler (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  logic ps_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ps_q <= 1'b0;
    else         ps_q <= ~ps_q;
  end

  assign tick_o = ps_q;

  // R2
  ps_alternate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ps_q |=> !ps_q);
endmodule

// File: rtl/mmd_cell.sv
module mmd_cell
  import mmd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic swallow_en_i,
  input  logic mod_i,
  output logic tick_o,
  output logic mod_o,
  output logic term_o
);
  cell_cnt_t cnt_q;
  cell_cnt_t last;

  // divide by three only in the sub-cycle flagged by the next stage
  assign last   = (swallow_en_i && mod_i) ? 2'd2 : 2'd1;
  assign term_o = (cnt_q == last);
  assign tick_o = tick_i && term_o;
  assign mod_o  = mod_i && term_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= term_o ? 2'd0 : cnt_q + 2'd1;
  end

  // R2
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q != 2'd3);

  // R2
  swallow_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == 2'd2) |-> (swallow_en_i && mod_i));
endmodule

// File: rtl/mmd_resync.sv
module mmd_resync #(
  parameter int unsigned NUM_CELLS = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 set_i,
  input  logic [NUM_CELLS-1:0] term_i,
  output logic                 q_o
);
  localparam logic [NUM_CELLS-1:0] CLR_STATE = {{(NUM_CELLS-1){1'b1}}, 1'b0};

  logic q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  q_q <= 1'b0;
    else if (set_i)               q_q <= 1'b1;
    else if (term_i == CLR_STATE) q_q <= 1'b0;
  end

  assign q_o = q_q;

  // R3
  rise_on_terminal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(q_q) |-> $past(set_i));

  // R5
  clear_before_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (term_i == CLR_STATE) |=> !q_q);
endmodule

// File: rtl/mmd_divider.sv
module mmd_divider #(
  parameter int unsigned NUM_CELLS = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_CELLS-1:0] ratio_sel_i,
  output logic                 div_o
);
  logic                 pre_tick;
  logic [NUM_CELLS-1:0] ratio_q;
  logic [NUM_CELLS-1:0] tick_in;
  logic [NUM_CELLS-1:0] tick_out;
  logic [NUM_CELLS-1:0] mod_in;
  logic [NUM_CELLS-1:0] mod_out;
  logic [NUM_CELLS-1:0] term;
  logic                 period_end;

  mmd_prescaler u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (pre_tick)
  );

  for (genvar k = 0; k < NUM_CELLS; k++) begin : g_cell
    if (k == 0) begin : g_first
      assign tick_in[k] = pre_tick;
    end else begin : g_next
      assign tick_in[k] = tick_out[k-1];
    end
    if (k == NUM_CELLS - 1) begin : g_last
      assign mod_in[k] = 1'b1;
    end else begin : g_mid
      assign mod_in[k] = mod_out[k+1];
    end

    mmd_cell u_cell (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .tick_i       (tick_in[k]),
      .swallow_en_i (ratio_q[k]),
      .mod_i        (mod_in[k]),
      .tick_o       (tick_out[k]),
      .mod_o        (mod_out[k]),
      .term_o       (term[k])
    );
  end

  assign period_end = tick_out[NUM_CELLS-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         ratio_q <= '0;
    else if (period_end) ratio_q <= ratio_sel_i;
  end

  mmd_resync #(.NUM_CELLS(NUM_CELLS)) u_resync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (mod_out[0]),
    .term_i (term),
    .q_o    (div_o)
  );

  // R4
  ratio_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !period_end |=> $stable(ratio_q));

  // R4
  load_all_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_end |-> (&term));
endmodule

// File: tb/mmd_divider_tb.sv
module mmd_divider_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] ratio_sel_i = 3'd0;
  logic       div_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk_i = ~clk_i;

  mmd_divider u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ratio_sel_i (ratio_sel_i),
    .div_o       (div_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int ratio_of(input int w);
    return 2 * (8 + 4 * ((w >> 2) & 1) + 2 * ((w >> 1) & 1) + (w & 1));
  endfunction

  initial begin
    int  c = 0;
    int  nrise = 0;
    int  next_rise = -1;
    int  low_w = 0;
    int  cur_word = 0;
    int  since = 0;
    bit  synced = 0;
    logic prev = 1'b0;

    // R1: output held low in reset
    for (int i = 0; i < 4; i++) begin
      @(posedge clk_i); #1;
      check(div_o == 1'b0, "R1", div_o, 0);
    end
    rst_ni = 1'b1;

    while (nrise < 37 && c < 20000) begin
      logic rose;
      @(posedge clk_i); #1;
      c++;
      rose = div_o && !prev;
      prev = div_o;

      if (synced) begin
        if (c == next_rise)
          check(rose, (nrise > 24) ? "R4" : "R2", rose, 1);
        else
          check(!rose, "R3", rose, 0);
      end

      if (rose) begin
        if (synced && nrise >= 2)
          check(low_w == 2 * (1 + (cur_word & 1)), "R5", low_w, 2 * (1 + (cur_word & 1)));
        low_w = 0;
        nrise++;
        if (nrise <= 24) ratio_sel_i = 3'((nrise - 1) / 3);
        cur_word  = int'(ratio_sel_i);
        next_rise = c + ratio_of(cur_word);
        synced    = 1;
        since     = 0;
      end else begin
        if (!div_o) low_w++;
        since++;
        // R4: change mid-period; must only affect the next period
        if (nrise > 24 && since == 5)
          ratio_sel_i = (nrise % 2 == 1) ? 3'd7 : 3'd0;
      end
    end

    if (nrise < 37) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d rising edges", nrise, 37);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule